// File: doc/BRIEF.md
# Shared-Pin Power-Down Controller

This block owns one active-low board pin whose meaning changes after power-up. For a fixed number of reference-clock cycles after reset, called the power-on window, the pin acts as a tristate control: holding it low asks the pad ring to float every clock output. When the window closes, the block captures the configuration strap levels. If the pin is high at that moment and the function-select register bit asks for it, the pin becomes a power-down request from then on. If the pin is low at that moment, it stays a tristate control until the next reset.

A power-down request only counts after it has been seen low on two consecutive rising edges of the host clock. Each gated output clock then parks low at its own next falling edge, so no output ever shows a shortened high pulse. The oscillator-run indication drops for the whole power-down. When the request is released, a settle counter runs first. After it expires, each parked output restarts on a rising edge of its own source clock.

All logic runs on one free-running reference clock. The host clock and the source clocks arrive as levels sampled on that clock.

Top module: `shared_pin_ctrl`

## Requirements
- R1: While reset is high, every gated output, `pd_active`, `hiz` and `strap_q` are 0, and `osc_run` is 1.
- R2: While the pin acts as a tristate control, `hiz` equals the inverse of `pin_n` sampled on the previous reference-clock edge.
- R3: On the reference edge numbered WINDOW_CYC after reset is released, `strap_q` loads `strap_in`. It then holds that value until the next reset, whatever `strap_in` does.
- R4: `pin_is_pd` is 1 exactly when the window has closed, `pin_n` was high on that closing edge, and `pin_sel_pd` is 1. `pin_sel_pd` = 1 selects power-down and 0 selects tristate.
- R5: If `pin_n` was low on the window-closing edge, the pin stays a tristate control, and `pd_active` stays 0 until the next reset.
- R6: While `pin_sel_pd` is 0, the pin acts as a tristate control, and any power-down in progress ends on the next edge.
- R7: `pd_active` sets on the reference edge at which the second consecutive host-clock rising edge is seen with `pin_n` low in power-down mode. A high `pin_n` on any reference edge clears both `pd_active` and the sample count.
- R8: While `pd_active` is 1, each output is forced low from the reference edge at which its source clock falls, and stays low. Every high pulse it drives keeps the full source-clock width.
- R9: `osc_run` is 0 exactly while `pd_active` is 1.
- R10: After `pd_active` clears, the settle counter runs for SETTLE_CYC cycles. Only after that does a parked output restart, on the edge at which its source clock rises.
- R11: An output that is not parked equals its source clock delayed by one reference-clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| pin_n | input | 1 | Shared active-low pin (tristate control or power-down request) |
| pin_sel_pd | input | 1 | Register bit: 1 selects power-down function, 0 tristate |
| host_clk | input | 1 | Host clock level, sampled for rising edges |
| strap_in | input | STRAP_W | Strap levels present on the shared output pads |
| src_clk | input | N_OUT | Ungated source clock for each output |
| clk_out | output | N_OUT | Gated output clocks |
| hiz | output | 1 | Float-all-outputs request to the pad ring |
| pd_active | output | 1 | Qualified power-down state |
| osc_run | output | 1 | Oscillator and VCO run indication |
| pin_is_pd | output | 1 | Shared pin currently acts as power-down input |
| strap_q | output | STRAP_W | Latched configuration straps |

## Verification
The bench drives pin pulses short enough to cover only a single host-clock rising edge. A design that qualifies on one sample, or keeps its count across a release, would enter power-down there. Every high pulse on each output is measured, so parking on the request edge instead of the falling edge, or restarting mid-phase, shows up as a short pulse. Separate resets hold the pin low at the window's closing edge, change the straps after the window, and toggle the function-select bit. These expose a pin that wrongly becomes a power-down input, straps that keep following their inputs, and outputs that restart before the settle count has run out.

// File: rtl/spc_pkg.sv
package spc_pkg;
  // Function currently assigned to the shared pin
  typedef enum logic {
    PIN_FN_TRI = 1'b0,
    PIN_FN_PD  = 1'b1
  } pin_fn_e;
endpackage

// File: rtl/spc_window_fsm.sv
module spc_window_fsm #(
  parameter int WINDOW_CYC = 21477,
  parameter int STRAP_W    = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pin_n,
  input  logic [STRAP_W-1:0] strap_in,
  output logic               window_done,
  output logic               pd_capable,
  output logic [STRAP_W-1:0] strap_q
);
  localparam int WW = $clog2(WINDOW_CYC + 1);
  localparam logic [WW-1:0] LAST = WW'(WINDOW_CYC - 1);

  logic [WW-1:0] win_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_cnt     <= '0;
      window_done <= 1'b0;
      pd_capable  <= 1'b0;
      strap_q     <= '0;
    end else if (!window_done) begin
      if (win_cnt == LAST) begin
        window_done <= 1'b1;
        pd_capable  <= pin_n;   // a held tristate request keeps the pin as tristate
        strap_q     <= strap_in;
      end else begin
        win_cnt <= win_cnt + 1'b1;
      end
    end
  end

  AST_WINDOW_STICKY: assert property (@(posedge clk) disable iff (rst)
    window_done |=> window_done); // R3
  AST_STRAP_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (window_done && $past(window_done)) |-> $stable(strap_q)); // R3
endmodule

// File: rtl/spc_pd_qual.sv
module spc_pd_qual #(
  parameter int QUAL_EDGES = 2,
  parameter int SETTLE_CYC = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic host_clk,
  input  logic pin_n,
  input  logic mode_pd,
  output logic pd_active,
  output logic settle_done
);
  localparam int QW = $clog2(QUAL_EDGES) + 1;
  localparam int SW = $clog2(SETTLE_CYC) + 1;
  localparam logic [QW-1:0] QLAST = QW'(QUAL_EDGES - 1);
  localparam logic [SW-1:0] SLAST = SW'(SETTLE_CYC - 1);

  logic          host_q;
  logic          host_rise;
  logic [QW-1:0] qual_cnt;
  logic [SW-1:0] settle_cnt;

  assign host_rise = host_clk & ~host_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      host_q      <= 1'b0;
      qual_cnt    <= '0;
      pd_active   <= 1'b0;
      settle_cnt  <= '0;
      settle_done <= 1'b1;
    end else begin
      host_q <= host_clk;
      if (!mode_pd || pin_n) begin
        qual_cnt  <= '0;
        pd_active <= 1'b0;
      end else if (host_rise) begin
        if (qual_cnt == QLAST) pd_active <= 1'b1;
        if (qual_cnt < QLAST)  qual_cnt  <= qual_cnt + 1'b1;
      end
      if (pd_active) begin
        settle_cnt  <= '0;
        settle_done <= 1'b0;
      end else if (!settle_done) begin
        if (settle_cnt == SLAST) settle_done <= 1'b1;
        else                     settle_cnt  <= settle_cnt + 1'b1;
      end
    end
  end

  AST_PD_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_active) |-> ($past(mode_pd) && !$past(pin_n) && $past(host_rise))); // R7
  AST_PD_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (pin_n && pd_active) |=> !pd_active); // R7
endmodule

// File: rtl/spc_lane.sv
module spc_lane (
  input  logic clk,
  input  logic rst,
  input  logic src_clk,
  input  logic pd_active,
  input  logic settle_done,
  output logic clk_out
);
  logic src_q;
  logic parked;
  logic park_nx;

  always_comb begin
    park_nx = parked;
    if (pd_active && src_q && !src_clk)
      park_nx = 1'b1;                       // falling edge of the source: stop here
    else if (!pd_active && settle_done && !src_q && src_clk)
      park_nx = 1'b0;                       // rising edge after settle: resume
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q   <= 1'b0;
      parked  <= 1'b0;
      clk_out <= 1'b0;
    end else begin
      src_q   <= src_clk;
      parked  <= park_nx;
      clk_out <= src_clk & ~park_nx;
    end
  end

  AST_PARK_AFTER_HIGH: assert property (@(posedge clk) disable iff (rst)
    $rose(parked) |-> ($past(clk_out) && !clk_out)); // R8
  AST_RESTART_HIGH: assert property (@(posedge clk) disable iff (rst)
    $fell(parked) |-> clk_out); // R10
  AST_RISE_FOLLOWS_SRC: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_out) |-> $past(src_clk)); // R11
endmodule

// File: rtl/shared_pin_ctrl.sv
module shared_pin_ctrl #(
  parameter int N_OUT      = 8,
  parameter int STRAP_W    = 5,
  parameter int WINDOW_CYC = 21477,
  parameter int QUAL_EDGES = 2,
  parameter int SETTLE_CYC = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pin_n,
  input  logic               pin_sel_pd,
  input  logic               host_clk,
  input  logic [STRAP_W-1:0] strap_in,
  input  logic [N_OUT-1:0]   src_clk,
  output logic [N_OUT-1:0]   clk_out,
  output logic               hiz,
  output logic               pd_active,
  output logic               osc_run,
  output logic               pin_is_pd,
  output logic [STRAP_W-1:0] strap_q
);
  import spc_pkg::*;

  logic    window_done;
  logic    pd_capable;
  logic    settle_done;
  pin_fn_e pin_fn;

  spc_window_fsm #(.WINDOW_CYC(WINDOW_CYC), .STRAP_W(STRAP_W)) u_window (
    .clk(clk), .rst(rst), .pin_n(pin_n), .strap_in(strap_in),
    .window_done(window_done), .pd_capable(pd_capable), .strap_q(strap_q)
  );

  assign pin_fn    = (window_done && pd_capable && pin_sel_pd) ? PIN_FN_PD : PIN_FN_TRI;
  assign pin_is_pd = (pin_fn == PIN_FN_PD);

  spc_pd_qual #(.QUAL_EDGES(QUAL_EDGES), .SETTLE_CYC(SETTLE_CYC)) u_qual (
    .clk(clk), .rst(rst), .host_clk(host_clk), .pin_n(pin_n), .mode_pd(pin_is_pd),
    .pd_active(pd_active), .settle_done(settle_done)
  );

  assign osc_run = ~pd_active;

  always_ff @(posedge clk) begin
    if (rst) hiz <= 1'b0;
    else     hiz <= (pin_fn == PIN_FN_TRI) && !pin_n;
  end

  for (genvar g = 0; g < N_OUT; g++) begin : g_lane
    spc_lane u_lane (
      .clk(clk), .rst(rst), .src_clk(src_clk[g]), .pd_active(pd_active),
      .settle_done(settle_done), .clk_out(clk_out[g])
    );
  end

  AST_HIZ_FROM_PIN: assert property (@(posedge clk) disable iff (rst)
    $rose(hiz) |-> !$past(pin_n)); // R2
  AST_NO_PD_IN_TRI: assert property (@(posedge clk) disable iff (rst)
    !window_done |-> !pd_active); // R5
  AST_OSC_STOP: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_active) |-> !osc_run); // R9
endmodule

// File: tb/shared_pin_ctrl_bench.sv
module shared_pin_ctrl_bench;
  localparam int N   = 4;
  localparam int SW  = 5;
  localparam int WIN = 40;
  localparam int SET = 8;
  localparam int QL  = 2;

  logic clk = 1'b0, rst = 1'b1, pin_n = 1'b1, sel = 1'b1, host = 1'b0;
  logic [SW-1:0] strap = '0;
  logic [N-1:0]  raw = '0;
  logic [N-1:0]  clk_out;
  logic hiz, pd_active, osc_run, pin_is_pd;
  logic [SW-1:0] strap_q;
  int checks = 0, errors = 0;
  bit finished = 0;

  shared_pin_ctrl #(.N_OUT(N), .STRAP_W(SW), .WINDOW_CYC(WIN), .QUAL_EDGES(QL),
                    .SETTLE_CYC(SET)) u_shared_pin_ctrl (
    .clk(clk), .rst(rst), .pin_n(pin_n), .pin_sel_pd(sel), .host_clk(host),
    .strap_in(strap), .src_clk(raw), .clk_out(clk_out), .hiz(hiz),
    .pd_active(pd_active), .osc_run(osc_run), .pin_is_pd(pin_is_pd), .strap_q(strap_q)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int half_period(input int lane);
    return lane + 2;
  endfunction

  // source and host clocks, driven away from the active edge
  int hcnt = 0;
  int lcnt [N];
  always @(negedge clk) begin
    hcnt++;
    if (hcnt == 3) begin hcnt = 0; host <= ~host; end
    for (int i = 0; i < N; i++) begin
      lcnt[i]++;
      if (lcnt[i] == half_period(i)) begin lcnt[i] = 0; raw[i] <= ~raw[i]; end
    end
  end

  // requirement model
  logic m_hostq, m_pd, m_sdone, m_wdone, m_cap, m_hiz;
  int m_q, m_scnt, m_wcnt;
  logic [N-1:0] m_rawq, m_stop, m_out;
  logic [SW-1:0] m_strap;
  int run [N];
  bit armed [N];
  logic prev_o [N];

  always @(posedge clk) begin : model
    logic mpd, rise, nst;
    if (rst) begin
      m_hostq = 0; m_pd = 0; m_sdone = 1; m_wdone = 0; m_cap = 0; m_hiz = 0;
      m_q = 0; m_scnt = 0; m_wcnt = 0; m_rawq = '0; m_stop = '0; m_out = '0; m_strap = '0;
      for (int i = 0; i < N; i++) begin run[i] = 0; armed[i] = 0; prev_o[i] = 0; end
    end else begin
      mpd  = m_wdone && m_cap && sel;
      rise = host && !m_hostq;
      for (int i = 0; i < N; i++) begin
        nst = m_stop[i];
        if (m_pd && m_rawq[i] && !raw[i]) nst = 1;
        else if (!m_pd && m_sdone && !m_rawq[i] && raw[i]) nst = 0;
        m_stop[i] = nst;
        m_out[i]  = raw[i] && !nst;
      end
      m_rawq = raw;
      if (m_pd) begin m_scnt = 0; m_sdone = 0; end
      else if (!m_sdone) begin
        if (m_scnt == SET - 1) m_sdone = 1; else m_scnt++;
      end
      if (!mpd || pin_n) begin m_q = 0; m_pd = 0; end
      else if (rise) begin
        if (m_q == QL - 1) m_pd = 1;
        if (m_q < QL - 1) m_q++;
      end
      m_hostq = host;
      m_hiz = !mpd && !pin_n;
      if (!m_wdone) begin
        if (m_wcnt == WIN - 1) begin m_wdone = 1; m_cap = pin_n; m_strap = strap; end
        else m_wcnt++;
      end
    end
    #5;
    if (!rst && !finished) begin
      chk("R8 R10 R11 clk_out", clk_out, m_out);
      chk("R7 pd_active", pd_active, m_pd);
      chk("R9 osc_run", osc_run, !m_pd);
      chk("R2 R5 R6 hiz", hiz, m_hiz);
      chk("R3 strap_q", strap_q, m_strap);
      chk("R4 pin_is_pd", pin_is_pd, m_wdone && m_cap && sel);
      for (int i = 0; i < N; i++) begin
        if (prev_o[i] && !clk_out[i]) begin
          if (armed[i]) chk("R8 high pulse width", run[i], half_period(i));
          armed[i] = 1;
        end
        run[i] = clk_out[i] ? run[i] + 1 : 0;
        prev_o[i] = clk_out[i];
      end
    end
  end

  task automatic start(input logic pin_at_win, input logic [SW-1:0] s, input logic sv);
    @(negedge clk);
    rst = 1; pin_n = pin_at_win; strap = s; sel = sv;
    repeat (3) @(negedge clk);
    chk("R1 reset clk_out", clk_out, '0);
    chk("R1 reset pd_active", pd_active, 0);
    chk("R1 reset osc_run", osc_run, 1);
    chk("R1 reset hiz", hiz, 0);
    chk("R1 reset strap_q", strap_q, '0);
    rst = 0;
    repeat (WIN + 2) @(negedge clk);
    strap = ~s;  // straps must stay locked (R3)
  endtask

  task automatic hold(input logic v, input int n);
    pin_n = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic random_pin(input int iters, input bit flip_sel);
    for (int k = 0; k < iters; k++) begin
      if (flip_sel && ($urandom_range(0, 3) == 0)) sel = ~sel;
      hold(0, $urandom_range(1, 14));
      hold(1, $urandom_range(1, 30));
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    // phase 1: pin high at window end, power-down function selected
    start(1'b1, 5'h15, 1'b1);
    hold(1, 5);
    hold(0, 4);   // short request: at most one host rising edge (R7)
    hold(1, 10);
    hold(0, 40);  // qualified request, outputs park (R8)
    hold(1, 60);  // release, settle, restart (R10)
    random_pin(60, 1'b0);
    // phase 2: pin low at window end stays tristate control (R5)
    start(1'b0, 5'h0A, 1'b1);
    random_pin(25, 1'b0);
    // phase 3: function-select bit toggles (R6)
    start(1'b1, 5'h1C, 1'b0);
    random_pin(40, 1'b1);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog R1 actual running expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule